// File: doc/BRIEF.md
# Serial Control Port for an Audio Processor

This block is the write-only control port of an audio processor. It watches a two-wire serial bus (I2C clock and data) with the system clock, finds START and STOP conditions, and receives bytes MSB first. It answers only its own device address in write mode, acknowledges each byte it accepts by pulling the data line low in the ninth clock, and fills a small bank of 8-bit control registers.

The byte after the device address picks a register. Its low nibble is the register index. Its top bit chooses how the data bytes that follow are placed: either all of them go to that one register, or each one goes to the next index, and the index wraps from 15 to 0. Data aimed at an index that holds no register is acknowledged and then dropped. Every register that takes a write makes a one-cycle update strobe that carries its index. At reset each register loads its own preset: first input selected, input attenuation at maximum, surround off with fixed output and the effect fully attenuated, both speaker channels muted, and fixed tone presets.

Top module: `audio_ctl_i2c_slave`

## Requirements
- R1: After reset the register bus holds, per index: 0 = 0x03 (input select), 1 = 0x3F (input attenuation), 2 = 0x6F (surround/effect), 3 = 0x01 (phase), 4 = 0x0F (bass), 5 = 0x0E (treble), 6 = 0xFF (left speaker), 9 = 0xFF (right speaker), and indices 7 and 8 read 0x00. Register index i sits at bits [8i+7:8i] of `ctl_regs_o`.
- R2: A START is SDA falling while SCL is high and a STOP is SDA rising while SCL is high. No byte is accepted until a START has been seen.
- R3: After a START, the first byte is acknowledged only when it equals 0x80 (7-bit address 0x40 with the write bit 0). Any other first byte gets no acknowledge, and the block ignores the bus until the next START.
- R4: The second byte is always acknowledged. Its bits 3:0 give the register index, bit 7 is the increment flag, and bits 6:4 have no effect.
- R5: With the increment flag at 0, every data byte before STOP or START is written to the same index.
- R6: With the increment flag at 1, each data byte goes to the index after the previous byte's index, and the index wraps from 15 to 0.
- R7: Data bytes aimed at index 7, 8 or 10 to 15 are acknowledged, change no register and make no strobe.
- R8: A data byte that lands updates its register in the same cycle that `upd_stb_o` goes high for exactly one cycle, with `upd_idx_o` at the index. The registers change at no other time.
- R9: A START or STOP in the middle of a byte discards the partial byte. After a repeated START the block again expects the device address.
- R10: `sda_oe_o` is high only during acknowledge slots. It is never high while a data bit is clocked, and it changes only while SCL is low.
- R11: Bits arrive MSB first: the first bit on the bus becomes bit 7 of the stored byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | Pull data line low (open-drain enable) |
| upd_stb_o | output | 1 | One-cycle strobe on each register write |
| upd_idx_o | output | 4 | Index of the register written with the strobe |
| ctl_regs_o | output | NREG*8 | All control registers, index i at [8i+7:8i] |

## Verification
On every cycle the assertions check four things: the strobe lasts one cycle, the registers change only with the strobe, each strobe falls inside an acknowledge slot, and the acknowledge driver switches only while SCL is low. Other behaviour depends on what was sent on the bus, so only the bench's scenarios can show it. That covers address matching, where each data byte lands in repeat and increment modes, the wrap from 15 to 0, dropped bytes at empty indices, aborted partial bytes, and the reset presets.

// File: rtl/audio_ctl_pkg.sv
package audio_ctl_pkg;

  localparam int IDX_W   = 4;
  localparam int REG_NUM = 10;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RX   = 2'd1,
    PH_ACK  = 2'd2
  } phase_t;

  typedef enum logic [1:0] {
    BK_ADDR = 2'd0,
    BK_SUB  = 2'd1,
    BK_DATA = 2'd2
  } kind_t;

  // Index holds a register: inside the bank and not one of the empty codes.
  function automatic logic idx_writable(input logic [IDX_W-1:0] idx, input int nreg);
    return (int'(idx) < nreg) && (idx != 4'd7) && (idx != 4'd8);
  endfunction

  function automatic logic [7:0] idx_preset(input int idx);
    case (idx)
      0:       return 8'h03;  // first input
      1:       return 8'h3F;  // input attenuation maximum
      2:       return 8'h6F;  // surround off, fixed out, effect max
      3:       return 8'h01;  // phase network
      4:       return 8'h0F;  // bass preset
      5:       return 8'h0E;  // treble preset
      6:       return 8'hFF;  // left speaker muted
      9:       return 8'hFF;  // right speaker muted
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_ff, sda_ff;
  logic              scl_prev, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff   <= '1;
      sda_ff   <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_ff   <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff   <= {sda_ff[STAGES-2:0], sda_i};
      scl_prev <= scl_ff[STAGES-1];
      sda_prev <= sda_ff[STAGES-1];
    end
  end

  assign scl_lvl   = scl_ff[STAGES-1];
  assign sda_lvl   = sda_ff[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/i2c_wr_engine.sv
module i2c_wr_engine
  import audio_ctl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             sda_lvl,
  input  logic             start_det,
  input  logic             stop_det,
  output logic             sda_oe,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data
);

  localparam logic [7:0] ADDR_BYTE = {DEV_ADDR, 1'b0};

  phase_t           phase_q, phase_d;
  kind_t            kind_q, kind_d;
  logic [3:0]       cnt_q, cnt_d;
  logic [7:0]       shr_q, shr_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             inc_q, inc_d;
  logic             wr_q, wr_d;

  always_comb begin
    phase_d = phase_q;
    kind_d  = kind_q;
    cnt_d   = cnt_q;
    shr_d   = shr_q;
    idx_d   = idx_q;
    inc_d   = inc_q;
    wr_d    = 1'b0;
    if (stop_det) begin
      phase_d = PH_IDLE;
    end else if (start_det) begin
      phase_d = PH_RX;
      kind_d  = BK_ADDR;
      cnt_d   = '0;
    end else begin
      case (phase_q)
        PH_RX: begin
          if (scl_rise) begin
            shr_d = {shr_q[6:0], sda_lvl};
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            if (kind_q == BK_ADDR && shr_q != ADDR_BYTE) phase_d = PH_IDLE;
            else                                         phase_d = PH_ACK;
          end
        end
        PH_ACK: begin
          if (scl_rise) begin
            if (kind_q == BK_SUB) begin
              idx_d = shr_q[IDX_W-1:0];
              inc_d = shr_q[7];
            end
            if (kind_q == BK_DATA) wr_d = 1'b1;
          end else if (scl_fall) begin
            phase_d = PH_RX;
            cnt_d   = '0;
            kind_d  = (kind_q == BK_ADDR) ? BK_SUB : BK_DATA;
            if (kind_q == BK_DATA && inc_q) idx_d = idx_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      kind_q  <= BK_ADDR;
      cnt_q   <= '0;
      shr_q   <= '0;
      idx_q   <= '0;
      inc_q   <= 1'b0;
      wr_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      kind_q  <= kind_d;
      cnt_q   <= cnt_d;
      shr_q   <= shr_d;
      idx_q   <= idx_d;
      inc_q   <= inc_d;
      wr_q    <= wr_d;
    end
  end

  assign sda_oe  = (phase_q == PH_ACK);
  assign wr_en   = wr_q;
  assign wr_idx  = idx_q;
  assign wr_data = shr_q;

endmodule

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank
  import audio_ctl_pkg::*;
#(
  parameter int NREG = REG_NUM
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [7:0]        wr_data,
  output logic [NREG*8-1:0] regs_flat,
  output logic              upd_stb,
  output logic [IDX_W-1:0]  upd_idx
);

  logic lands;
  assign lands = wr_en & idx_writable(wr_idx, NREG);

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    if (idx_writable(IDX_W'(g), NREG)) begin : g_reg
      logic [7:0] val_q;
      logic       ld;
      assign ld = lands && (wr_idx == IDX_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  val_q <= idx_preset(g);
        else if (ld) val_q <= wr_data;
      end
      assign regs_flat[g*8 +: 8] = val_q;
    end else begin : g_empty
      assign regs_flat[g*8 +: 8] = 8'h00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_stb <= 1'b0;
      upd_idx <= '0;
    end else begin
      upd_stb <= lands;
      if (lands) upd_idx <= wr_idx;
    end
  end

endmodule

// File: rtl/audio_ctl_i2c_slave.sv
module audio_ctl_i2c_slave
  import audio_ctl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h40,
  parameter int         NREG        = REG_NUM,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic              upd_stb_o,
  output logic [IDX_W-1:0]  upd_idx_o,
  output logic [NREG*8-1:0] ctl_regs_o
);

  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [7:0]       wr_data;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_wr_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_lvl   (sda_lvl),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe_o),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data)
  );

  ctl_reg_bank #(.NREG(NREG)) u_bank (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .regs_flat (ctl_regs_o),
    .upd_stb   (upd_stb_o),
    .upd_idx   (upd_idx_o)
  );

endmodule

// File: rtl/audio_ctl_i2c_slave_chk.sv
module audio_ctl_i2c_slave_chk #(
  parameter int NREG = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe_o,
  input logic              upd_stb_o,
  input logic [NREG*8-1:0] ctl_regs_o
);

  // R8
  stb_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb_o |=> !upd_stb_o);

  // R8
  regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_stb_o |-> $stable(ctl_regs_o));

  // R10
  stb_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(upd_stb_o) |-> sda_oe_o);

  // R10
  oe_rise_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> !scl_i);

  // R10
  oe_fall_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe_o) |-> !scl_i);

endmodule

bind audio_ctl_i2c_slave audio_ctl_i2c_slave_chk #(.NREG(NREG)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scl_i      (scl_i),
  .sda_oe_o   (sda_oe_o),
  .upd_stb_o  (upd_stb_o),
  .ctl_regs_o (ctl_regs_o)
);

// File: tb/audio_ctl_i2c_slave_tb.sv
`timescale 1ns/1ps
module audio_ctl_i2c_slave_tb;

  localparam int NREG = 10;
  localparam int Q    = 20;
  localparam int H    = 40;

  logic             clk;
  logic             rst_n;
  logic             scl;
  logic             sda_m;
  logic             sda_line;
  logic             sda_oe_o;
  logic             upd_stb_o;
  logic [3:0]       upd_idx_o;
  logic [NREG*8-1:0] ctl_regs_o;

  assign sda_line = sda_m & ~sda_oe_o;

  audio_ctl_i2c_slave u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl),
    .sda_i      (sda_line),
    .sda_oe_o   (sda_oe_o),
    .upd_stb_o  (upd_stb_o),
    .upd_idx_o  (upd_idx_o),
    .ctl_regs_o (ctl_regs_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  int stb_cnt  = 0;
  int stb_wide = 0;
  int oe_bad   = 0;
  logic [3:0] stb_idx = '0;
  logic       stb_prev = 1'b0;
  logic [7:0] exp_r [NREG];

  always @(negedge clk) begin
    if (rst_n && upd_stb_o) begin
      stb_cnt++;
      stb_idx = upd_idx_o;
      if (stb_prev) stb_wide++;
    end
    stb_prev = upd_stb_o;
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_val(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [7:0] reg_of(input int i);
    return ctl_regs_o[i*8 +: 8];
  endfunction

  task automatic check_regs(input string tag);
    for (int i = 0; i < NREG; i++) check_val(tag, reg_of(i), exp_r[i]);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wait_clk(Q);
    scl = 1'b1;   wait_clk(Q);
    sda_m = 1'b0; wait_clk(Q);
    scl = 1'b0;   wait_clk(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wait_clk(Q);
    scl = 1'b1;   wait_clk(Q);
    sda_m = 1'b1; wait_clk(Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wait_clk(Q);
    scl = 1'b1; wait_clk(H/2);
    if (sda_oe_o) oe_bad++;
    wait_clk(H/2);
    scl = 1'b0; wait_clk(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) send_bit(b[i]);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; wait_clk(Q);
    scl = 1'b1; wait_clk(H/2);
    ack = sda_oe_o;
    wait_clk(H/2);
    scl = 1'b0; wait_clk(Q);
  endtask

  // Full write: START, device address, register byte, n data bytes, STOP.
  task automatic write_seq(input string tag, input logic [7:0] sub,
                           input logic [7:0] d0, input logic [7:0] d1,
                           input logic [7:0] d2, input logic [7:0] d3, input int n);
    logic a;
    logic [7:0] d [4];
    d[0] = d0; d[1] = d1; d[2] = d2; d[3] = d3;
    bus_start;
    send_byte(8'h80, a); check_val({tag, " R3 addr ack"}, a, 1);
    send_byte(sub, a);   check_val({tag, " R4 sub ack"}, a, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(d[i], a); check_val({tag, " R7 data ack"}, a, 1);
    end
    bus_stop;
  endtask

  task automatic t_reset;
    for (int i = 0; i < NREG; i++) exp_r[i] = 8'h00;
    exp_r[0] = 8'h03; exp_r[1] = 8'h3F; exp_r[2] = 8'h6F; exp_r[3] = 8'h01;
    exp_r[4] = 8'h0F; exp_r[5] = 8'h0E; exp_r[6] = 8'hFF; exp_r[9] = 8'hFF;
    check_regs("R1 reset presets");
    check_val("R10 oe idle after reset", sda_oe_o, 0);
    check_val("R8 no strobe after reset", stb_cnt, 0);
  endtask

  task automatic t_no_start;
    logic a;
    int s0 = stb_cnt;
    scl = 1'b0; wait_clk(Q);
    send_byte(8'h80, a); check_val("R2 no ack without START", a, 0);
    send_byte(8'h01, a);
    send_byte(8'h42, a);
    bus_stop;
    check_val("R2 no write without START", stb_cnt - s0, 0);
    check_regs("R2 regs unchanged");
  endtask

  task automatic t_repeat_mode;
    logic a;
    int s0 = stb_cnt;
    bus_start;
    send_byte(8'h80, a); check_val("R3 addr ack", a, 1);
    send_byte(8'h01, a); check_val("R4 sub ack", a, 1);
    send_byte(8'h12, a);
    wait_clk(4);
    check_val("R11 MSB first", reg_of(1), 8'h12);
    send_byte(8'h34, a);
    bus_stop;
    exp_r[1] = 8'h34;
    check_regs("R5 repeat to one index");
    check_val("R5 strobe count", stb_cnt - s0, 2);
    check_val("R8 strobe index", stb_idx, 1);
  endtask

  task automatic t_incr_mode;
    int s0 = stb_cnt;
    write_seq("incr", 8'h84, 8'hA1, 8'hB2, 8'hC3, 8'h00, 3);
    exp_r[4] = 8'hA1; exp_r[5] = 8'hB2; exp_r[6] = 8'hC3;
    check_regs("R6 increment sequence");
    check_val("R6 strobe count", stb_cnt - s0, 3);
    check_val("R8 last strobe index", stb_idx, 6);
    s0 = stb_cnt;
    write_seq("dontcare", 8'h72, 8'h5A, 8'h00, 8'h00, 8'h00, 1);
    exp_r[2] = 8'h5A;
    check_regs("R4 bits 6:4 ignored");
    check_val("R4 strobe index", stb_idx, 2);
  endtask

  task automatic t_wrap;
    int s0 = stb_cnt;
    write_seq("wrap", 8'h8F, 8'h11, 8'h22, 8'h00, 8'h00, 2);
    exp_r[0] = 8'h22;
    check_regs("R6 wrap 15 to 0");
    check_val("R7 index 15 dropped", stb_cnt - s0, 1);
    check_val("R6 wrap strobe index", stb_idx, 0);
  endtask

  task automatic t_reserved;
    int s0 = stb_cnt;
    write_seq("rsv7", 8'h07, 8'h99, 8'h98, 8'h00, 8'h00, 2);
    check_val("R7 no strobe at index 7", stb_cnt - s0, 0);
    check_regs("R7 index 7 dropped");
    s0 = stb_cnt;
    write_seq("rsvinc", 8'h86, 8'h61, 8'h77, 8'h88, 8'h69, 4);
    exp_r[6] = 8'h61; exp_r[9] = 8'h69;
    check_regs("R7 skip 7 and 8");
    check_val("R7 strobe count", stb_cnt - s0, 2);
    check_val("R8 strobe index 9", stb_idx, 9);
  endtask

  task automatic t_bad_addr;
    logic a;
    int s0 = stb_cnt;
    bus_start;
    send_byte(8'h82, a); check_val("R3 wrong address nack", a, 0);
    send_byte(8'h03, a); check_val("R3 idle after nack", a, 0);
    send_byte(8'h55, a);
    bus_stop;
    bus_start;
    send_byte(8'h81, a); check_val("R3 read bit nack", a, 0);
    send_byte(8'h03, a);
    send_byte(8'h55, a);
    bus_stop;
    check_val("R3 no write", stb_cnt - s0, 0);
    check_regs("R3 regs unchanged");
  endtask

  task automatic t_abort;
    logic a;
    int s0 = stb_cnt;
    bus_start;
    send_byte(8'h80, a);
    send_byte(8'h01, a);
    send_bits(8'hF0, 4);
    bus_start;
    send_byte(8'h80, a); check_val("R9 address after repeated START", a, 1);
    send_byte(8'h05, a);
    send_byte(8'h3C, a);
    bus_stop;
    exp_r[5] = 8'h3C;
    check_regs("R9 partial byte dropped on START");
    check_val("R9 one strobe", stb_cnt - s0, 1);
    s0 = stb_cnt;
    bus_start;
    send_byte(8'h80, a);
    send_byte(8'h03, a);
    send_bits(8'h00, 5);
    bus_stop;
    check_val("R9 no strobe on STOP abort", stb_cnt - s0, 0);
    check_regs("R9 partial byte dropped on STOP");
  endtask

  task automatic t_final;
    check_val("R10 oe never high in data bits", oe_bad, 0);
    check_val("R8 strobe one cycle wide", stb_wide, 0);
  endtask

  initial begin
    rst_n = 1'b0; scl = 1'b1; sda_m = 1'b1;
    wait_clk(10);
    rst_n = 1'b1;
    wait_clk(10);
    t_reset;
    t_no_start;
    t_repeat_mode;
    t_incr_mode;
    t_wrap;
    t_reserved;
    t_bad_addr;
    t_abort;
    t_final;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule